// File: doc/BRIEF.md
# Directional Tap Detector for Three-Axis Acceleration Samples

This block watches a stream of signed acceleration samples for three axes (X, Y, Z) that arrive together under one sample strobe. Each axis passes through a fixed second-order high-pass filter that removes gravity and slow tilt. A short impulse is then picked out of the filtered value. An impulse counts as a tap when its magnitude reaches a per-axis threshold and it drops back below that threshold within a per-axis sample limit. The tap's direction is the sign of the strongest filtered sample in the excursion.

Each axis reports on two event lines, one for positive taps and one for negative taps. Each line has its own enable, and a per-axis swap bit exchanges the two lines. After a reported tap, the axis ignores a programmable number of samples. A global enable turns all detection off. The block is meant to sit between a sample front end and a status or interrupt unit that latches the single-cycle event pulses.

Top module: `tap_detector`

## Requirements
- R1: On each strobe, every axis computes f = s[n] - 2*s[n-1] + s[n-2] from its current raw sample and its previous two strobed raw samples. The result is clamped to ±(2^(SW-1)-1). Reset sets the stored history to zero.
- R2: A filtered sample is "over" when |f| >= the axis threshold (THR_W-bit unsigned, threshold of axis a at `thr_cfg[a*THR_W +: THR_W]`). |f| one below the threshold is not over.
- R3: A tap is declared on the first non-over sample that follows a run of over samples. The pulse appears on `tap_evt` in the clock cycle right after the strobe edge of that sample and lasts one cycle.
- R4: A run of more than `dur` consecutive over samples (DUR_W bits per axis at `dur_cfg[a*DUR_W +: DUR_W]`) gives no tap. A run of exactly `dur` samples gives a tap. When dur = 0, no tap is ever produced.
- R5: The tap sign is the sign of the largest-magnitude filtered sample in the run. On equal magnitudes, the earliest sample sets the sign. At most one of an axis's two lines pulses at a time.
- R6: `tap_evt` bit 2a is the positive line of axis a and bit 2a+1 is its negative line (axis 0 = X, 1 = Y, 2 = Z). `dir_en` uses the same bit layout. A tap on a disabled line is not reported and does not start the quiet period.
- R7: `swap_dir[a]` = 1 reports a positive tap of axis a on bit 2a+1 and a negative tap on bit 2a.
- R8: While `det_on` is low, no event is produced. Each clock with `det_on` low also clears every run and quiet count, strobe or not.
- R9: Filter history, runs and quiet counts change only on strobe cycles (apart from reset and R8). Raw inputs presented without a strobe have no effect. `tap_evt` is zero in every cycle that does not follow a strobe edge.
- R10: After a tap reported on sample k with quiet value Q (`quiet_cfg[a*QUIET_W +: QUIET_W]`), samples k+1 to k+Q of that axis are ignored. Sample k+Q+1 can start a new run.
- R11: The axes are independent. Taps on several axes can be reported in the same cycle, and quiet on one axis does not block the others.
- R12: A synchronous active-high `rst` clears `tap_evt` and all internal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe for all three axes |
| smp_x | input | SW | X raw sample, two's complement |
| smp_y | input | SW | Y raw sample, two's complement |
| smp_z | input | SW | Z raw sample, two's complement |
| det_on | input | 1 | Global detection enable |
| dir_en | input | 6 | Per-line enables, bit 2a positive, 2a+1 negative |
| swap_dir | input | 3 | Per-axis positive/negative exchange |
| thr_cfg | input | 3*THR_W | Per-axis magnitude thresholds |
| dur_cfg | input | 3*DUR_W | Per-axis maximum run length in samples |
| quiet_cfg | input | 3*QUIET_W | Per-axis samples ignored after a tap |
| tap_evt | output | 6 | Registered single-cycle tap events |

## Verification
The assertions assume that configuration inputs are synchronous and change only between sample strobes. They compare events with the enables and global switch sampled at the preceding strobe edge. The bench drives every input on the falling edge. It constructs raw samples by running the inverse of the filter equation, so it fixes the filtered sequence exactly. This keeps every filtered value well inside the clamp limits, except in a separate raw-sample test that drives the filter equation directly. Each scenario starts from a reset, so the integrated raw samples stay far from the sample width.

// File: rtl/tap_pkg.sv
`timescale 1ns/1ps
package tap_pkg;
  localparam int NAX = 3;
  localparam int NEV = 2 * NAX;

  typedef enum logic [1:0] {
    SGN_POS = 2'b01,
    SGN_NEG = 2'b10
  } tap_sign_e;
endpackage

// File: rtl/tap_hpf.sv
`timescale 1ns/1ps
module tap_hpf #(
  parameter int SW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stb,
  input  logic signed [SW-1:0] din,
  output logic signed [SW-1:0] dout
);
  localparam int EW = SW + 2;
  localparam logic signed [EW-1:0] POS_LIM = {3'b000, {(SW-1){1'b1}}};
  localparam logic signed [EW-1:0] NEG_LIM = -POS_LIM;

  logic signed [SW-1:0] hist1_q, hist2_q;
  logic signed [EW-1:0] ext0, ext1, ext2, acc;

  assign ext0 = {{2{din[SW-1]}}, din};
  assign ext1 = {{2{hist1_q[SW-1]}}, hist1_q};
  assign ext2 = {{2{hist2_q[SW-1]}}, hist2_q};
  // zeros at DC twice: x - 2*x1 + x2 with a shift for the doubling
  assign acc  = ext0 - (ext1 <<< 1) + ext2;

  always_comb begin
    if (acc > POS_LIM)      dout = POS_LIM[SW-1:0];
    else if (acc < NEG_LIM) dout = NEG_LIM[SW-1:0];
    else                    dout = acc[SW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist1_q <= '0;
      hist2_q <= '0;
    end else if (stb) begin
      hist1_q <= din;
      hist2_q <= hist1_q;
    end
  end
endmodule

// File: rtl/tap_qualify.sv
`timescale 1ns/1ps
module tap_qualify #(
  parameter int SW      = 16,
  parameter int THR_W   = 8,
  parameter int DUR_W   = 4,
  parameter int QUIET_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stb,
  input  logic                 arm,
  input  logic signed [SW-1:0] filt,
  input  logic [THR_W-1:0]     thr,
  input  logic [DUR_W-1:0]     dur,
  input  logic [QUIET_W-1:0]   quiet,
  input  logic                 taken,
  output logic                 hit,
  output logic                 hit_neg
);
  localparam int RW = DUR_W + 1;
  localparam logic [RW-1:0] RUN_MAX = {1'b1, {DUR_W{1'b0}}};

  logic [RW-1:0]        run_q;
  logic [QUIET_W-1:0]   qcnt_q;
  logic signed [SW-1:0] peak_q;
  logic [SW-1:0]        mag, peak_mag, thr_ext;
  logic                 over, quiet_act, fall_ok;

  assign mag       = filt[SW-1] ? $unsigned(-filt) : $unsigned(filt);
  assign peak_mag  = peak_q[SW-1] ? $unsigned(-peak_q) : $unsigned(peak_q);
  assign thr_ext   = SW'(thr);
  assign over      = (mag >= thr_ext);
  assign quiet_act = (qcnt_q != '0);
  assign fall_ok   = !quiet_act && !over && (run_q != '0) && (run_q <= {1'b0, dur});
  assign hit       = stb && arm && fall_ok;
  assign hit_neg   = peak_q[SW-1];

  always_ff @(posedge clk) begin
    if (rst || !arm) begin
      run_q  <= '0;
      qcnt_q <= '0;
      peak_q <= '0;
    end else if (stb) begin
      if (quiet_act) begin
        qcnt_q <= qcnt_q - QUIET_W'(1);
        run_q  <= '0;
      end else if (over) begin
        if (run_q == '0 || mag > peak_mag) peak_q <= filt;
        if (run_q != RUN_MAX) run_q <= run_q + RW'(1);
      end else begin
        run_q <= '0;
        if (fall_ok && taken) qcnt_q <= quiet;
      end
    end
  end
endmodule

// File: rtl/tap_route.sv
`timescale 1ns/1ps
module tap_route
  import tap_pkg::*;
(
  input  logic [NAX-1:0] hit,
  input  logic [NAX-1:0] neg,
  input  logic [NAX-1:0] swap,
  input  logic [NEV-1:0] en,
  output logic [NEV-1:0] evt,
  output logic [NAX-1:0] taken
);
  for (genvar a = 0; a < NAX; a++) begin : g_ax
    tap_sign_e line;
    assign line         = (neg[a] ^ swap[a]) ? SGN_NEG : SGN_POS;
    assign evt[2*a]     = hit[a] && (line == SGN_POS) && en[2*a];
    assign evt[2*a+1]   = hit[a] && (line == SGN_NEG) && en[2*a+1];
    assign taken[a]     = evt[2*a] || evt[2*a+1];
  end
endmodule

// File: rtl/tap_detector.sv
`timescale 1ns/1ps
module tap_detector
  import tap_pkg::*;
#(
  parameter int SW      = 16,
  parameter int THR_W   = 8,
  parameter int DUR_W   = 4,
  parameter int QUIET_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   smp_vld,
  input  logic [SW-1:0]          smp_x,
  input  logic [SW-1:0]          smp_y,
  input  logic [SW-1:0]          smp_z,
  input  logic                   det_on,
  input  logic [NEV-1:0]         dir_en,
  input  logic [NAX-1:0]         swap_dir,
  input  logic [NAX*THR_W-1:0]   thr_cfg,
  input  logic [NAX*DUR_W-1:0]   dur_cfg,
  input  logic [NAX*QUIET_W-1:0] quiet_cfg,
  output logic [NEV-1:0]         tap_evt
);
  logic signed [SW-1:0] raw  [NAX];
  logic signed [SW-1:0] filt [NAX];
  logic [NAX-1:0] hit, neg, taken;
  logic [NEV-1:0] evt_d;

  assign raw[0] = smp_x;
  assign raw[1] = smp_y;
  assign raw[2] = smp_z;

  for (genvar a = 0; a < NAX; a++) begin : g_axis
    tap_hpf #(.SW(SW)) u_hpf (
      .clk (clk), .rst (rst), .stb (smp_vld),
      .din (raw[a]), .dout (filt[a])
    );
    tap_qualify #(.SW(SW), .THR_W(THR_W), .DUR_W(DUR_W), .QUIET_W(QUIET_W)) u_qual (
      .clk     (clk),
      .rst     (rst),
      .stb     (smp_vld),
      .arm     (det_on),
      .filt    (filt[a]),
      .thr     (thr_cfg[a*THR_W +: THR_W]),
      .dur     (dur_cfg[a*DUR_W +: DUR_W]),
      .quiet   (quiet_cfg[a*QUIET_W +: QUIET_W]),
      .taken   (taken[a]),
      .hit     (hit[a]),
      .hit_neg (neg[a])
    );
  end

  tap_route u_route (
    .hit (hit), .neg (neg), .swap (swap_dir), .en (dir_en),
    .evt (evt_d), .taken (taken)
  );

  always_ff @(posedge clk) begin
    if (rst) tap_evt <= '0;
    else     tap_evt <= evt_d;
  end
endmodule

// File: rtl/tap_detector_chk.sv
`timescale 1ns/1ps
module tap_detector_chk
  import tap_pkg::*;
(
  input logic           clk,
  input logic           rst,
  input logic           smp_vld,
  input logic           det_on,
  input logic [NEV-1:0] dir_en,
  input logic [NEV-1:0] tap_evt
);
  assert_evt_after_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    (|tap_evt) |-> $past(smp_vld));

  assert_global_off_R8: assert property (@(posedge clk) disable iff (rst)
    $past(!det_on) |-> (tap_evt == '0));

  assert_line_enable_R6: assert property (@(posedge clk) disable iff (rst)
    (|tap_evt) |-> ((tap_evt & ~$past(dir_en)) == '0));

  for (genvar a = 0; a < NAX; a++) begin : g_chk
    assert_one_dir_R5: assert property (@(posedge clk) disable iff (rst)
      !(tap_evt[2*a] && tap_evt[2*a+1]));
    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
      (tap_evt[2*a] || tap_evt[2*a+1]) |=> !(tap_evt[2*a] || tap_evt[2*a+1]));
  end
endmodule

bind tap_detector tap_detector_chk u_chk (
  .clk (clk), .rst (rst), .smp_vld (smp_vld), .det_on (det_on),
  .dir_en (dir_en), .tap_evt (tap_evt)
);

// File: tb/tap_detector_tb.sv
`timescale 1ns/1ps
module tap_detector_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_vld = 1'b0;
  logic [15:0] smp_x = '0, smp_y = '0, smp_z = '0;
  logic det_on = 1'b1;
  logic [5:0] dir_en = '1;
  logic [2:0] swap_dir = '0;
  logic [23:0] thr_cfg = '0;
  logic [11:0] dur_cfg = '0, quiet_cfg = '0;
  logic [5:0] tap_evt;

  int checks = 0, fails = 0;
  int h1[3], h2[3];
  logic [5:0] ev;

  always #2.5 clk = ~clk;

  tap_detector u_dut (
    .clk (clk), .rst (rst), .smp_vld (smp_vld),
    .smp_x (smp_x), .smp_y (smp_y), .smp_z (smp_z),
    .det_on (det_on), .dir_en (dir_en), .swap_dir (swap_dir),
    .thr_cfg (thr_cfg), .dur_cfg (dur_cfg), .quiet_cfg (quiet_cfg),
    .tap_evt (tap_evt)
  );

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: tap_evt actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic set_axis(input int a, input int thr, input int dur, input int q);
    thr_cfg[a*8 +: 8]   = 8'(thr);
    dur_cfg[a*4 +: 4]   = 4'(dur);
    quiet_cfg[a*4 +: 4] = 4'(q);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; smp_vld = 1'b0; det_on = 1'b1; dir_en = '1; swap_dir = '0;
    for (int a = 0; a < 3; a++) begin set_axis(a, 50, 4, 0); h1[a] = 0; h2[a] = 0; end
    smp_x = '0; smp_y = '0; smp_z = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // drives raw samples chosen so that the filter output equals the requested values
  task automatic step(input int fx, input int fy, input int fz, output logic [5:0] e);
    int fv[3]; int xs[3];
    fv = '{fx, fy, fz};
    @(negedge clk);
    for (int a = 0; a < 3; a++) begin
      xs[a] = fv[a] + 2*h1[a] - h2[a];
      h2[a] = h1[a]; h1[a] = xs[a];
    end
    smp_x = 16'(xs[0]); smp_y = 16'(xs[1]); smp_z = 16'(xs[2]);
    smp_vld = 1'b1;
    @(negedge clk);
    e = tap_evt;
    smp_vld = 1'b0;
  endtask

  task automatic step_raw_x(input int xv, output logic [5:0] e);
    @(negedge clk);
    h2[0] = h1[0]; h1[0] = xv;
    smp_x = 16'(xv); smp_vld = 1'b1;
    @(negedge clk);
    e = tap_evt;
    smp_vld = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R12 reset clears events", tap_evt, 6'b0);
  endtask

  task automatic t_basic();
    logic [5:0] acc;
    do_reset();
    acc = '0;
    step(0, 0, 0, ev);  acc |= ev;
    step(80, 0, 0, ev); acc |= ev;
    step(90, 0, 0, ev); acc |= ev;
    chk("R3 no event during excursion", acc, 6'b0);
    step(0, 0, 0, ev);
    chk("R3 positive X tap on fall", ev, 6'b000001);
    @(negedge clk);
    chk("R9 pulse lasts one cycle", tap_evt, 6'b0);
  endtask

  task automatic t_raw_filter();
    logic [5:0] acc;
    do_reset();
    set_axis(0, 200, 2, 0);
    acc = '0;
    step_raw_x(0, ev);    acc |= ev;
    step_raw_x(1000, ev); acc |= ev;
    step_raw_x(1500, ev); acc |= ev;
    chk("R1 raw filter no early event", acc, 6'b0);
    step_raw_x(2000, ev);
    chk("R1 second difference 1000,-500,0 gives XP", ev, 6'b000001);
  endtask

  task automatic t_sign();
    do_reset();
    step(0, 60, 70, ev);
    step(0, -90, -70, ev);
    step(0, 0, 0, ev);
    chk("R5 R11 Y peak negative, Z tie earliest positive", ev, 6'b011000);
  endtask

  task automatic t_thresh();
    do_reset();
    step(49, 0, 0, ev);
    step(0, 0, 0, ev);
    chk("R2 magnitude thr-1 not over", ev, 6'b0);
    step(-50, 0, 0, ev);
    step(0, 0, 0, ev);
    chk("R2 magnitude equal to thr qualifies", ev, 6'b000010);
  endtask

  task automatic t_duration();
    do_reset();
    set_axis(0, 50, 3, 0);
    for (int i = 0; i < 3; i++) step(60, 0, 0, ev);
    step(0, 0, 0, ev);
    chk("R4 run equal to dur accepted", ev, 6'b000001);
    for (int i = 0; i < 4; i++) step(60, 0, 0, ev);
    step(0, 0, 0, ev);
    chk("R4 run longer than dur rejected", ev, 6'b0);
    set_axis(0, 50, 0, 0);
    step(60, 0, 0, ev);
    step(0, 0, 0, ev);
    chk("R4 dur zero rejects all", ev, 6'b0);
  endtask

  task automatic t_quiet();
    do_reset();
    set_axis(0, 50, 4, 2);
    step(60, 0, 0, ev);
    step(0, 0, 0, ev);
    chk("R10 first tap before quiet", ev, 6'b000001);
    step(60, 60, 0, ev);
    step(0, 0, 0, ev);
    chk("R10 R11 X ignored in quiet, Y still reports", ev, 6'b000100);
    step(60, 0, 0, ev);
    step(0, 0, 0, ev);
    chk("R10 detection rearmed after quiet", ev, 6'b000001);
  endtask

  task automatic t_flip();
    do_reset();
    swap_dir = 3'b001;
    step(60, -60, 0, ev);
    step(0, 0, 0, ev);
    chk("R7 X swapped, Y not swapped", ev, 6'b001010);
  endtask

  task automatic t_enable();
    do_reset();
    dir_en = 6'b111110;
    set_axis(0, 50, 4, 3);
    step(80, 0, 0, ev);
    step(0, 0, 0, ev);
    chk("R6 disabled positive line not reported", ev, 6'b0);
    step(-80, 0, 0, ev);
    step(0, 0, 0, ev);
    chk("R6 unreported tap starts no quiet", ev, 6'b000010);
  endtask

  task automatic t_global();
    do_reset();
    det_on = 1'b0;
    step(80, 0, 0, ev);
    step(0, 0, 0, ev);
    chk("R8 global off blocks taps", ev, 6'b0);
    det_on = 1'b1;
    step(80, 0, 0, ev);
    @(negedge clk); det_on = 1'b0;
    @(negedge clk); det_on = 1'b1;
    step(0, 0, 0, ev);
    chk("R8 global off clears run", ev, 6'b0);
    step(80, 0, 0, ev);
    step(0, 0, 0, ev);
    chk("R8 detection works when re-enabled", ev, 6'b000001);
  endtask

  task automatic t_strobe();
    logic [5:0] acc;
    do_reset();
    step(80, 0, 0, ev);
    acc = '0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      smp_x = 16'sd20000; smp_y = -16'sd20000; smp_z = 16'sd12345;
      acc |= tap_evt;
    end
    chk("R9 no event without strobe", acc, 6'b0);
    step(0, 0, 0, ev);
    chk("R9 unstrobed inputs leave filter history intact", ev, 6'b000001);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_raw_filter();
    t_sign();
    t_thresh();
    t_duration();
    t_quiet();
    t_flip();
    t_enable();
    t_global();
    t_strobe();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule